// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block holds the atomic-access reservation for a single hardware thread. A load-linked access records the physical address it touched, rounded down to a 16-byte granule, and arms a reservation flag. A later store-conditional is judged against that reservation. The block then reports whether the store may go to memory and which result code the pipeline writes back: 0 for a failed attempt, 1 for a successful one, and 2 for an uncacheable store. Code 2 bypasses the check and tells the pipeline to leave the destination register unchanged.

An invalidate input clears the reservation. It is driven by a snooped write to the line or by a return from an exception. The block also watches for livelock. It counts store-conditionals that fail back to back, pulses a warning on every tenth consecutive failure, and raises a sticky fatal flag once the run of failures reaches 5000.

Top module: `resv_monitor`

## Requirements
- R1: A load-linked request stores its address with the low 4 bits forced to zero and arms the reservation. A later cacheable store-conditional to any byte of the same 16-byte granule is therefore judged a match.
- R2: A cacheable store-conditional succeeds only when the reservation is armed and its granule address equals the stored one. It then returns code 1, asserts the forward output and disarms the reservation.
- R3: A cacheable store-conditional that does not succeed returns code 0, leaves the forward output low and disarms the reservation.
- R4: An uncacheable store-conditional always returns code 2 with the forward output high. It leaves both the reservation and the failure count unchanged.
- R5: An asserted invalidate disarms the reservation. A cacheable store-conditional in the same cycle fails. A load-linked in the same cycle as an invalidate still arms the new reservation.
- R6: When a load-linked and a store-conditional arrive in the same cycle, the store is judged against the reservation that was held before that cycle. The new reservation is then captured.
- R7: The done, forward and code outputs are registered. They are valid in the cycle after the store-conditional request. Done, forward and code are zero in every cycle after one with no request.
- R8: Each failed cacheable store-conditional adds one to a consecutive-failure count, and a successful one returns the count to zero.
- R9: The warning output is a one-cycle pulse in the cycle after the failure count steps onto a nonzero multiple of 10.
- R10: The livelock flag rises in the cycle after the count steps onto 5000 and then stays high until reset. The count saturates at 5000, so later failures produce no warning.
- R11: A synchronous active-high reset disarms the reservation and clears the stored address, the failure count and the livelock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_valid | input | 1 | Load-linked request this cycle |
| ll_addr | input | ADDR_W | Physical address of the load-linked access |
| sc_valid | input | 1 | Store-conditional request this cycle |
| sc_addr | input | ADDR_W | Physical address of the store-conditional |
| sc_uncached | input | 1 | Store-conditional targets uncacheable space |
| inval | input | 1 | Clear the reservation (snoop hit or exception return) |
| sc_done | output | 1 | Result outputs valid (cycle after the request) |
| sc_fwd | output | 1 | Send the store to memory |
| sc_code | output | 2 | Result code: 0 fail, 1 success, 2 uncacheable bypass |
| fail_warn | output | 1 | One-cycle pulse on every tenth consecutive failure |
| livelock | output | 1 | Sticky flag: 5000 consecutive failures reached |

## Verification
Assertions check several rules on every cycle. The failure count never exceeds its limit. The livelock flag never drops without reset. A warning only ever accompanies a count that is a nonzero multiple of ten. A success always zeroes the count. An uncacheable request always yields code 2 with forwarding, and a failure code is never forwarded. A load-linked always leaves the reservation armed. The bench scenarios are needed for behaviour that depends on history. This covers granule matching across the low address bits and the priority between invalidate, load-linked and store-conditional in the same cycle. It also covers the exact cycle on which the 5000th failure raises livelock, and saturation after it.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    SC_FAIL   = 2'd0,
    SC_PASS   = 2'd1,
    SC_BYPASS = 2'd2
  } sc_code_e;
endpackage

// File: rtl/resv_store.sv
module resv_store #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              clr,
  output logic              armed,
  output logic [ADDR_W-1:0] base
);
  localparam logic [ADDR_W-1:0] GMASK = ADDR_W'((64'd1 << GRAN_BITS) - 64'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      base  <= '0;
    end else if (ll_valid) begin
      armed <= 1'b1;
      base  <= ll_addr & ~GMASK;
    end else if (clr) begin
      armed <= 1'b0;
    end
  end

  // R1
  ll_arms_chk: assert property (@(posedge clk) disable iff (rst)
    ll_valid |=> armed);

  // R5
  clr_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !ll_valid) |=> !armed);
endmodule

// File: rtl/resv_judge.sv
module resv_judge
  import resv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sc_valid,
  input  logic              sc_uncached,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              inval,
  input  logic              armed,
  input  logic [ADDR_W-1:0] base,
  output logic              consume,
  output logic              pass_evt,
  output logic              fail_evt,
  output logic              done_q,
  output logic              fwd_q,
  output sc_code_e          code_q
);
  localparam logic [ADDR_W-1:0] GMASK = ADDR_W'((64'd1 << GRAN_BITS) - 64'd1);

  logic hit;

  always_comb begin
    hit      = armed && !inval && ((sc_addr & ~GMASK) == base);
    consume  = sc_valid && !sc_uncached;
    pass_evt = consume && hit;
    fail_evt = consume && !hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      fwd_q  <= 1'b0;
      code_q <= SC_FAIL;
    end else begin
      done_q <= sc_valid;
      if (!sc_valid) begin
        fwd_q  <= 1'b0;
        code_q <= SC_FAIL;
      end else if (sc_uncached) begin
        fwd_q  <= 1'b1;
        code_q <= SC_BYPASS;
      end else if (hit) begin
        fwd_q  <= 1'b1;
        code_q <= SC_PASS;
      end else begin
        fwd_q  <= 1'b0;
        code_q <= SC_FAIL;
      end
    end
  end

  // R3
  fail_not_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && code_q == SC_FAIL) |-> !fwd_q);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> (!fwd_q && code_q == SC_FAIL));
endmodule

// File: rtl/resv_livelock.sv
module resv_livelock #(
  parameter int WARN_PERIOD = 10,
  parameter int FATAL_LIMIT = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic pass_evt,
  input  logic fail_evt,
  output logic warn_q,
  output logic fatal_q
);
  localparam int CNT_W = $clog2(FATAL_LIMIT + 1);
  localparam int DEC_W = $clog2(WARN_PERIOD + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FATAL_LIMIT);
  localparam logic [DEC_W-1:0] DEC_TOP = DEC_W'(WARN_PERIOD - 1);

  logic [CNT_W-1:0] cnt;
  logic [DEC_W-1:0] dec;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      dec     <= '0;
      warn_q  <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      warn_q <= 1'b0;
      if (pass_evt) begin
        cnt <= '0;
        dec <= '0;
      end else if (fail_evt && cnt != LIMIT) begin
        cnt <= cnt + CNT_W'(1);
        if (dec == DEC_TOP) begin
          dec    <= '0;
          warn_q <= 1'b1;
        end else begin
          dec <= dec + DEC_W'(1);
        end
        if (cnt == LIMIT - CNT_W'(1)) fatal_q <= 1'b1;
      end
    end
  end

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);

  // R10
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fatal_q |=> fatal_q);

  // R9
  warn_mult_chk: assert property (@(posedge clk) disable iff (rst)
    warn_q |-> (cnt != '0 && (int'(cnt) % WARN_PERIOD) == 0));

  // R8
  pass_zero_chk: assert property (@(posedge clk) disable iff (rst)
    pass_evt |=> cnt == '0);

  // R8
  fail_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_evt && !pass_evt && cnt < LIMIT) |=> cnt == $past(cnt) + CNT_W'(1));
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 10,
  parameter int FATAL_LIMIT = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              sc_uncached,
  input  logic              inval,
  output logic              sc_done,
  output logic              sc_fwd,
  output logic [1:0]        sc_code,
  output logic              fail_warn,
  output logic              livelock
);
  logic              armed;
  logic [ADDR_W-1:0] base;
  logic              consume, pass_evt, fail_evt;
  sc_code_e          code_q;

  resv_store #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_store (
    .clk(clk), .rst(rst),
    .ll_valid(ll_valid), .ll_addr(ll_addr),
    .clr(inval | consume),
    .armed(armed), .base(base)
  );

  resv_judge #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_judge (
    .clk(clk), .rst(rst),
    .sc_valid(sc_valid), .sc_uncached(sc_uncached), .sc_addr(sc_addr),
    .inval(inval), .armed(armed), .base(base),
    .consume(consume), .pass_evt(pass_evt), .fail_evt(fail_evt),
    .done_q(sc_done), .fwd_q(sc_fwd), .code_q(code_q)
  );

  resv_livelock #(.WARN_PERIOD(WARN_PERIOD), .FATAL_LIMIT(FATAL_LIMIT)) u_live (
    .clk(clk), .rst(rst),
    .pass_evt(pass_evt), .fail_evt(fail_evt),
    .warn_q(fail_warn), .fatal_q(livelock)
  );

  assign sc_code = code_q;

  // R4
  bypass_code_chk: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && sc_uncached) |=> (sc_done && sc_fwd && sc_code == 2'd2));

  // R2
  pass_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (sc_done && sc_code == 2'd1) |-> sc_fwd);
endmodule

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb;
  localparam int AW = 32;
  localparam int LIMIT = 5000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ll_valid = 1'b0;
  logic [AW-1:0] ll_addr = '0;
  logic          sc_valid = 1'b0;
  logic [AW-1:0] sc_addr = '0;
  logic          sc_uncached = 1'b0;
  logic          inval = 1'b0;
  logic          sc_done, sc_fwd, fail_warn, livelock;
  logic [1:0]    sc_code;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  bit          m_armed = 0;
  logic [AW-1:0] m_base = '0;
  int          m_cnt = 0;
  bit          m_fatal = 0;
  int          warn_seen = 0;

  always #10 clk = ~clk;

  resv_monitor u_dut (
    .clk(clk), .rst(rst), .ll_valid(ll_valid), .ll_addr(ll_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
    .inval(inval), .sc_done(sc_done), .sc_fwd(sc_fwd), .sc_code(sc_code),
    .fail_warn(fail_warn), .livelock(livelock)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Starts and ends at a falling edge. Drives one cycle, predicts, checks.
  task automatic step(input bit do_ll, input logic [AW-1:0] la,
                      input bit do_sc, input logic [AW-1:0] sa,
                      input bit unc, input bit inv, input string tag);
    int  e_code = 0;
    bit  e_fwd = 0;
    bit  e_warn = 0;
    ll_valid = do_ll; ll_addr = la; sc_valid = do_sc; sc_addr = sa;
    sc_uncached = unc; inval = inv;
    if (do_sc) begin
      if (unc) begin
        e_code = 2; e_fwd = 1;
      end else if (m_armed && !inv && ((sa & ~32'hF) == m_base)) begin
        e_code = 1; e_fwd = 1; m_cnt = 0;
      end else begin
        if (m_cnt < LIMIT) begin
          m_cnt++;
          if (m_cnt % 10 == 0) e_warn = 1;
          if (m_cnt == LIMIT) m_fatal = 1;
        end
      end
    end
    if (do_ll) begin
      m_armed = 1; m_base = la & ~32'hF;
    end else if (inv || (do_sc && !unc)) begin
      m_armed = 0;
    end
    @(negedge clk);
    ll_valid = 0; sc_valid = 0; sc_uncached = 0; inval = 0;
    if (fail_warn) warn_seen++;
    chk(sc_done == do_sc, tag, "sc_done", sc_done, do_sc);
    chk(sc_code == e_code[1:0], tag, "sc_code", sc_code, e_code);
    chk(sc_fwd == e_fwd, tag, "sc_fwd", sc_fwd, e_fwd);
    chk(fail_warn == e_warn, tag, "fail_warn", fail_warn, e_warn);
    chk(livelock == m_fatal, tag, "livelock", livelock, m_fatal);
  endtask

  task automatic do_reset();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    m_armed = 0; m_base = '0; m_cnt = 0; m_fatal = 0;
  endtask

  task automatic t_reset_state();
    chk(sc_done == 0, "R11", "done after reset", sc_done, 0);
    chk(livelock == 0, "R11", "livelock after reset", livelock, 0);
    chk(fail_warn == 0, "R11", "warn after reset", fail_warn, 0);
    // no reservation after reset: SC must fail
    step(0, 0, 1, 32'h0, 0, 0, "R11");
    // idle cycle: outputs quiet
    step(0, 0, 0, 0, 0, 0, "R7");
  endtask

  task automatic t_granule();
    step(1, 32'h1000_0123, 0, 0, 0, 0, "R1");
    step(0, 0, 1, 32'h1000_012C, 0, 0, "R1");
    step(0, 0, 1, 32'h1000_012C, 0, 0, "R3");
    step(1, 32'h2000_0040, 0, 0, 0, 0, "R2");
    step(0, 0, 1, 32'h2000_0050, 0, 0, "R2");
    step(0, 0, 1, 32'h2000_0040, 0, 0, "R3");
  endtask

  task automatic t_uncached();
    step(1, 32'h3000_0000, 0, 0, 0, 0, "R4");
    step(0, 0, 1, 32'h9999_9999, 1, 0, "R4");
    step(0, 0, 1, 32'h3000_000F, 0, 0, "R4");
    step(0, 0, 1, 32'h1, 0, 0, "R8");
    step(0, 0, 1, 32'h1, 1, 0, "R4");
  endtask

  task automatic t_inval();
    step(1, 32'h4000_0000, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 1, "R5");
    step(0, 0, 1, 32'h4000_0000, 0, 0, "R5");
    step(1, 32'h4000_0000, 0, 0, 0, 0, "R5");
    step(0, 0, 1, 32'h4000_0000, 0, 1, "R5");
    step(1, 32'h4100_0000, 0, 0, 0, 1, "R5");
    step(0, 0, 1, 32'h4100_0008, 0, 0, "R5");
  endtask

  task automatic t_same_cycle();
    step(1, 32'h5000_0000, 0, 0, 0, 0, "R6");
    step(1, 32'h6000_0000, 1, 32'h5000_0004, 0, 0, "R6");
    step(0, 0, 1, 32'h6000_0000, 0, 0, "R6");
    step(1, 32'h7000_0000, 1, 32'h7000_0000, 0, 0, "R6");
    step(0, 0, 1, 32'h7000_0000, 0, 0, "R6");
  endtask

  task automatic t_warn();
    step(1, 32'h8000_0000, 0, 0, 0, 0, "R8");
    step(0, 0, 1, 32'h8000_0000, 0, 0, "R8");
    for (int i = 0; i < 25; i++) step(0, 0, 1, 32'h0, 0, 0, "R9");
    step(1, 32'h8000_0000, 0, 0, 0, 0, "R8");
    step(0, 0, 1, 32'h8000_0000, 0, 0, "R8");
    for (int i = 0; i < 10; i++) step(0, 0, 1, 32'h0, 0, 0, "R9");
  endtask

  task automatic t_livelock();
    step(1, 32'h8000_0000, 0, 0, 0, 0, "R10");
    step(0, 0, 1, 32'h8000_0000, 0, 0, "R10");
    warn_seen = 0;
    for (int i = 0; i < LIMIT; i++) step(0, 0, 1, 32'h0, 0, 0, "R10");
    chk(warn_seen == LIMIT / 10, "R9", "warn pulses", warn_seen, LIMIT / 10);
    warn_seen = 0;
    for (int i = 0; i < 30; i++) step(0, 0, 1, 32'h0, 0, 0, "R10");
    chk(warn_seen == 0, "R10", "warn after saturation", warn_seen, 0);
    step(1, 32'h8000_0000, 0, 0, 0, 0, "R10");
    step(0, 0, 1, 32'h8000_0000, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, "R10");
    do_reset();
    chk(livelock == 0, "R11", "livelock cleared", livelock, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 1, 32'h0, 0, 0, "R11");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_reset_state();
    t_granule();
    t_uncached();
    t_inval();
    t_same_cycle();
    t_warn();
    t_livelock();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule